// File: doc/BRIEF.md
# Character LCD Row-Scan Timing Generator

This block produces the row-scan timing for a character dot-matrix LCD. A slow oscillator tick, given as a clock enable, sets the pace. The block drives one common line at a time. While that row is on, it fetches the row slice of each of eight character cells from an external pattern source and shifts the 40 resulting segment bits out serially to a cascadable segment-driver chain. A latch pulse then moves the bits into the drivers' output latches at the moment the next common is selected. A polarity signal flips once per frame so that the panel sees an AC drive.

There are three scan formats, chosen by a line-count bit and a font-height bit. The block also applies the cursor underline and the blinking-cell overlay, and it blanks the segments when the display is switched off. The pattern source is a request/response stream. The block puts a character address and a row index on a request channel with valid/ready. The source returns the dot slice on a response channel with valid/ready. The block keeps at most one request outstanding. A request stays valid with a stable address and row until the source raises ready. The block raises response ready only while it waits for data, so the source may stall on either channel. The source must still deliver all eight slices of a row before that row's last oscillator tick.

Top module: `lcd_com_scan`

## Requirements
- R1: The number of commons scanned per frame is 8 when `two_line`=0 and `tall_font`=0, 11 when `two_line`=0 and `tall_font`=1, and 16 when `two_line`=1, whatever the value of `tall_font`. Commons are visited in ascending index order from 0.
- R2: Each common stays selected for ROW_LONG oscillator ticks (default 400) in the two one-line formats and for ROW_SHORT ticks (default 200) in the two-line format.
- R3: `com_o` is one-hot at all times, with bit i set for common i. Commons above the last active one stay at 0, which is the non-select level.
- R4: In each row, exactly 40 bits go out on `seg_data_o`, each taken on a rising edge of `seg_shift_o`. The data is stable on that edge. Character cells go in order 0 to 7, and within a cell the slice is sent bit 4 first (the leftmost dot), so the first bit sent belongs to segment 1.
- R5: `seg_latch_o` is high for exactly one oscillator tick, which is the last tick of each row. No shift edge occurs during it. On the tick that follows, `com_o` selects the common whose data was just shifted.
- R6: A slice is requested with address `line*0x40 + cell` and row `r`. In the two-line format, common c gives line `c/8` and row `c%8`. In the one-line formats, the line is 0 and the row is c.
- R7: `pat_req_addr` and `pat_req_row` stay stable while `pat_req_valid` is high and `pat_req_ready` is low. `pat_rsp_ready` is high only while no request is pending.
- R8: `ac_flip_o` starts at 0 and toggles exactly when the scan wraps from the last active common back to common 0.
- R9: When `cursor_on`=1, the cell whose address equals `cursor_addr` has all five dots of row 7 forced on, ORed with its pattern.
- R10: When `blink_on`=1 and the blink phase is 1, every row of the cell at `cursor_addr` is all dots on. The phase starts at 0 and flips after every BLINK_FRAMES frames (default 32).
- R11: When `disp_on`=0, every shifted segment bit is 0 and the commons keep scanning.
- R12: `two_line` and `tall_font` are sampled on the first oscillator tick of each frame. A change in the middle of a frame takes effect at the next frame.
- R13: While reset is held, `com_o`=0x0001 and `ac_flip_o`, `seg_latch_o`, `seg_shift_o`, `seg_data_o` and `pat_req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | Oscillator tick enable, one clk wide |
| two_line | input | 1 | 1 selects the two-line format |
| tall_font | input | 1 | 1 selects the 11-row cell (one-line only) |
| disp_on | input | 1 | 0 blanks all segment data |
| cursor_on | input | 1 | Enables the row-7 cursor |
| blink_on | input | 1 | Enables cursor-cell blinking |
| cursor_addr | input | 7 | Character address of the cursor |
| pat_req_valid | output | 1 | Slice request valid |
| pat_req_ready | input | 1 | Source accepts the request |
| pat_req_addr | output | 7 | Character address of the request |
| pat_req_row | output | 4 | Row index within the cell |
| pat_rsp_valid | input | 1 | Slice data valid |
| pat_rsp_ready | output | 1 | Block accepts slice data |
| pat_rsp_data | input | 5 | Dot slice, bit 4 leftmost |
| com_o | output | 16 | One-hot common select |
| seg_data_o | output | 1 | Serial segment data |
| seg_shift_o | output | 1 | Shift clock for the segment chain |
| seg_latch_o | output | 1 | Latch pulse for the segment chain |
| ac_flip_o | output | 1 | Frame polarity for AC drive |

## Verification
The latch pulse is due during the last oscillator tick of a row. `com_o` and `ac_flip_o` change on the clock edge where the pulse ends. The bench waits for the rising edge of the pulse at a falling clock edge and compares the 40 bits gathered since the previous pulse. It then waits for the pulse to fall before it samples the new common and the polarity. The spacing between pulses is checked against the row length times the oscillator divide ratio, and the pulse width against one divide period. The blink phase and the effect of a mode change are predicted from the frame count and the frame-start sampling rule, so each expected word matches the tick on which the slice was fetched.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;
  localparam int unsigned COM_N    = 16;
  localparam int unsigned COM_W    = 4;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned ROW_W    = 4;
  localparam int unsigned CUR_ROW  = 7;
  localparam int unsigned LINE2_AT = 64;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_REQ,
    SH_RSP,
    SH_LO,
    SH_HI
  } sh_state_e;

  // index of the last scanned common for a given format
  function automatic logic [COM_W-1:0] last_com(input logic two, input logic tall);
    if (two)       return COM_W'(15);
    else if (tall) return COM_W'(10);
    else           return COM_W'(7);
  endfunction

  function automatic logic [COM_W-1:0] next_com(input logic [COM_W-1:0] c,
                                                input logic two, input logic tall);
    return (c >= last_com(two, tall)) ? '0 : c + COM_W'(1);
  endfunction
endpackage

// File: rtl/lcd_scan_timer.sv
`timescale 1ns/1ps
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int unsigned ROW_LONG     = 400,
  parameter int unsigned ROW_SHORT    = 200,
  parameter int unsigned BLINK_FRAMES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             two_i,
  input  logic             tall_i,
  output logic             two_q_o,
  output logic [COM_W-1:0] com_idx_o,
  output logic [COM_W-1:0] tgt_o,
  output logic [COM_N-1:0] com_oh_o,
  output logic             row_start_o,
  output logic             latch_o,
  output logic             flip_o,
  output logic             blink_o
);
  localparam int unsigned TW  = $clog2(ROW_LONG + 1);
  localparam int unsigned BFW = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;

  logic [TW-1:0]    tick_q;
  logic [COM_W-1:0] com_q;
  logic             two_q, tall_q;
  logic             latch_q, flip_q, blink_q;
  logic [BFW-1:0]   fcnt_q;
  logic [TW-1:0]    row_len;
  logic             row_end, wrap, frame_first;

  assign row_len     = two_q ? TW'(ROW_SHORT) : TW'(ROW_LONG);
  assign row_end     = osc_en && (tick_q == row_len - TW'(1));
  assign wrap        = row_end && (com_q >= last_com(two_q, tall_q));
  assign frame_first = osc_en && (com_q == '0) && (tick_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      com_q   <= '0;
      two_q   <= 1'b0;
      tall_q  <= 1'b0;
      latch_q <= 1'b0;
      flip_q  <= 1'b0;
      blink_q <= 1'b0;
      fcnt_q  <= '0;
    end else if (osc_en) begin
      if (frame_first) begin
        two_q  <= two_i;
        tall_q <= tall_i;
      end
      latch_q <= (tick_q == row_len - TW'(2));
      if (row_end) begin
        tick_q <= '0;
        com_q  <= next_com(com_q, two_q, tall_q);
        if (wrap) begin
          flip_q <= ~flip_q;
          if (fcnt_q == BFW'(BLINK_FRAMES - 1)) begin
            fcnt_q  <= '0;
            blink_q <= ~blink_q;
          end else begin
            fcnt_q <= fcnt_q + BFW'(1);
          end
        end
      end else begin
        tick_q <= tick_q + TW'(1);
      end
    end
  end

  for (genvar i = 0; i < COM_N; i++) begin : g_com
    assign com_oh_o[i] = (com_q == COM_W'(i));
  end

  assign two_q_o     = two_q;
  assign com_idx_o   = com_q;
  assign tgt_o       = next_com(com_q, two_q, tall_q);
  assign row_start_o = osc_en && (tick_q == '0);
  assign latch_o     = latch_q;
  assign flip_o      = flip_q;
  assign blink_o     = blink_q;
endmodule

// File: rtl/lcd_scan_overlay.sv
`timescale 1ns/1ps
module lcd_scan_overlay
  import lcd_scan_pkg::*;
#(
  parameter int unsigned DOTS = 5
) (
  input  logic [DOTS-1:0]   raw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic              disp_on_i,
  input  logic              cur_on_i,
  input  logic              blink_on_i,
  input  logic              blink_ph_i,
  output logic [DOTS-1:0]   dots_o
);
  logic at_cursor, cur_line, blank_full;

  assign at_cursor  = (addr_i == cur_addr_i);
  assign cur_line   = cur_on_i && at_cursor && (row_i == ROW_W'(CUR_ROW));
  assign blank_full = blink_on_i && blink_ph_i && at_cursor;

  always_comb begin
    if (!disp_on_i)               dots_o = '0;
    else if (blank_full)          dots_o = '1;
    else if (cur_line)            dots_o = '1;
    else                          dots_o = raw_i;
  end
endmodule

// File: rtl/lcd_scan_shifter.sv
`timescale 1ns/1ps
module lcd_scan_shifter
  import lcd_scan_pkg::*;
#(
  parameter int unsigned CHARS = 8,
  parameter int unsigned DOTS  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              start_i,
  input  logic [COM_W-1:0]  tgt_i,
  input  logic              two_i,
  input  logic              disp_on_i,
  input  logic              cur_on_i,
  input  logic              blink_on_i,
  input  logic              blink_ph_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [ROW_W-1:0]  req_row_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DOTS-1:0]   rsp_data_i,
  output logic              sdata_o,
  output logic              sclk_o
);
  localparam int unsigned CW = (CHARS > 1) ? $clog2(CHARS) : 1;
  localparam int unsigned BW = (DOTS > 1) ? $clog2(DOTS) : 1;

  sh_state_e        st_q;
  logic [CW-1:0]    char_q;
  logic [BW-1:0]    bit_q;
  logic [DOTS-1:0]  sh_q;
  logic [COM_W-1:0] tgt_q;
  logic             sdata_q, sclk_q;
  logic [DOTS-1:0]  dots;
  logic             second_line;

  assign second_line = two_i && tgt_q[COM_W-1];
  assign req_addr_o  = (second_line ? ADDR_W'(LINE2_AT) : '0) + ADDR_W'(char_q);
  assign req_row_o   = two_i ? ROW_W'(tgt_q[2:0]) : ROW_W'(tgt_q);
  assign req_valid_o = (st_q == SH_REQ);
  assign rsp_ready_o = (st_q == SH_RSP);

  lcd_scan_overlay #(.DOTS(DOTS)) u_ovl (
    .raw_i      (rsp_data_i),
    .addr_i     (req_addr_o),
    .row_i      (req_row_o),
    .cur_addr_i (cur_addr_i),
    .disp_on_i  (disp_on_i),
    .cur_on_i   (cur_on_i),
    .blink_on_i (blink_on_i),
    .blink_ph_i (blink_ph_i),
    .dots_o     (dots)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SH_IDLE;
      char_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      tgt_q   <= '0;
      sdata_q <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      if (osc_en) sclk_q <= (st_q == SH_HI);
      unique case (st_q)
        SH_IDLE: if (start_i) begin
          tgt_q  <= tgt_i;
          char_q <= '0;
          st_q   <= SH_REQ;
        end
        SH_REQ: if (req_ready_i) st_q <= SH_RSP;
        SH_RSP: if (rsp_valid_i) begin
          sh_q  <= dots;
          bit_q <= '0;
          st_q  <= SH_LO;
        end
        SH_LO: if (osc_en) begin
          sdata_q <= sh_q[DOTS-1];
          st_q    <= SH_HI;
        end
        SH_HI: if (osc_en) begin
          sh_q <= sh_q << 1;
          if (bit_q == BW'(DOTS - 1)) begin
            if (char_q == CW'(CHARS - 1)) begin
              st_q <= SH_IDLE;
            end else begin
              char_q <= char_q + CW'(1);
              st_q   <= SH_REQ;
            end
          end else begin
            bit_q <= bit_q + BW'(1);
            st_q  <= SH_LO;
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign sdata_o = sdata_q;
  assign sclk_o  = sclk_q;
endmodule

// File: rtl/lcd_com_scan.sv
`timescale 1ns/1ps
module lcd_com_scan
  import lcd_scan_pkg::*;
#(
  parameter int unsigned ROW_LONG     = 400,
  parameter int unsigned ROW_SHORT    = 200,
  parameter int unsigned BLINK_FRAMES = 32,
  parameter int unsigned CHARS        = 8,
  parameter int unsigned DOTS         = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_en,
  input  logic        two_line,
  input  logic        tall_font,
  input  logic        disp_on,
  input  logic        cursor_on,
  input  logic        blink_on,
  input  logic [6:0]  cursor_addr,
  output logic        pat_req_valid,
  input  logic        pat_req_ready,
  output logic [6:0]  pat_req_addr,
  output logic [3:0]  pat_req_row,
  input  logic        pat_rsp_valid,
  output logic        pat_rsp_ready,
  input  logic [4:0]  pat_rsp_data,
  output logic [15:0] com_o,
  output logic        seg_data_o,
  output logic        seg_shift_o,
  output logic        seg_latch_o,
  output logic        ac_flip_o
);
  logic             two_q, row_start, blink_ph;
  logic [COM_W-1:0] com_idx, tgt;

  lcd_scan_timer #(
    .ROW_LONG     (ROW_LONG),
    .ROW_SHORT    (ROW_SHORT),
    .BLINK_FRAMES (BLINK_FRAMES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_en      (osc_en),
    .two_i       (two_line),
    .tall_i      (tall_font),
    .two_q_o     (two_q),
    .com_idx_o   (com_idx),
    .tgt_o       (tgt),
    .com_oh_o    (com_o),
    .row_start_o (row_start),
    .latch_o     (seg_latch_o),
    .flip_o      (ac_flip_o),
    .blink_o     (blink_ph)
  );

  lcd_scan_shifter #(
    .CHARS (CHARS),
    .DOTS  (DOTS)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_en      (osc_en),
    .start_i     (row_start),
    .tgt_i       (tgt),
    .two_i       (two_q),
    .disp_on_i   (disp_on),
    .cur_on_i    (cursor_on),
    .blink_on_i  (blink_on),
    .blink_ph_i  (blink_ph),
    .cur_addr_i  (cursor_addr),
    .req_valid_o (pat_req_valid),
    .req_ready_i (pat_req_ready),
    .req_addr_o  (pat_req_addr),
    .req_row_o   (pat_req_row),
    .rsp_valid_i (pat_rsp_valid),
    .rsp_ready_o (pat_rsp_ready),
    .rsp_data_i  (pat_rsp_data),
    .sdata_o     (seg_data_o),
    .sclk_o      (seg_shift_o)
  );

  logic unused_idx;
  assign unused_idx = ^com_idx;
endmodule

// File: rtl/lcd_com_scan_chk.sv
`timescale 1ns/1ps
module lcd_com_scan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        osc_en,
  input logic        pat_req_valid,
  input logic        pat_req_ready,
  input logic [6:0]  pat_req_addr,
  input logic [3:0]  pat_req_row,
  input logic        pat_rsp_ready,
  input logic [15:0] com_o,
  input logic        seg_data_o,
  input logic        seg_shift_o,
  input logic        seg_latch_o,
  input logic        ac_flip_o
);
  AST_COM_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_o) == 1); // R3
  AST_SHIFT_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seg_shift_o) |-> $stable(seg_data_o)); // R4
  AST_LATCH_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    seg_latch_o && osc_en |=> !seg_latch_o); // R5
  AST_NO_SHIFT_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    seg_latch_o |-> !seg_shift_o); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pat_req_valid && !pat_req_ready |=> pat_req_valid && $stable(pat_req_addr) && $stable(pat_req_row)); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rsp_ready |-> !pat_req_valid); // R7
  AST_FLIP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ac_flip_o) |-> com_o[0]); // R8
endmodule

bind lcd_com_scan lcd_com_scan_chk u_chk (.*);

// File: tb/lcd_com_scan_bench.sv
`timescale 1ns/1ps
module lcd_com_scan_bench;
  localparam int RL = 400;
  localparam int RS = 200;
  localparam int BF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0;
  logic two_line = 1'b0, tall_font = 1'b0, disp_on = 1'b1;
  logic cursor_on = 1'b0, blink_on = 1'b0;
  logic [6:0] cursor_addr = '0;
  logic pat_req_valid, pat_req_ready = 1'b0;
  logic [6:0] pat_req_addr;
  logic [3:0] pat_req_row;
  logic pat_rsp_valid = 1'b0, pat_rsp_ready;
  logic [4:0] pat_rsp_data = '0;
  logic [15:0] com_o;
  logic seg_data_o, seg_shift_o, seg_latch_o, ac_flip_o;

  int n_chk = 0, n_fail = 0;
  int div_sel = 1, stall = 0;

  always #2.5 clk = ~clk;

  lcd_com_scan #(.ROW_LONG(RL), .ROW_SHORT(RS), .BLINK_FRAMES(BF)) u_lcd_com_scan (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .two_line(two_line), .tall_font(tall_font),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on), .cursor_addr(cursor_addr),
    .pat_req_valid(pat_req_valid), .pat_req_ready(pat_req_ready), .pat_req_addr(pat_req_addr),
    .pat_req_row(pat_req_row), .pat_rsp_valid(pat_rsp_valid), .pat_rsp_ready(pat_rsp_ready),
    .pat_rsp_data(pat_rsp_data), .com_o(com_o), .seg_data_o(seg_data_o),
    .seg_shift_o(seg_shift_o), .seg_latch_o(seg_latch_o), .ac_flip_o(ac_flip_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] pat(int a, int r);
    return 5'((a * 7 + r * 13 + (a >> 1)) ^ r);
  endfunction

  function automatic int last_c(bit two, bit tall);
    return two ? 15 : (tall ? 10 : 7);
  endfunction

  function automatic logic [39:0] exp_word(int t, bit two, bit ph);
    logic [39:0] w = '0;
    for (int k = 0; k < 8; k++) begin
      int a = ((two && t >= 8) ? 64 : 0) + k;
      int r = two ? t % 8 : t;
      logic [4:0] p = pat(a, r);
      if (!disp_on) p = '0;
      else if (blink_on && ph && a == int'(cursor_addr)) p = 5'h1F;
      else if (cursor_on && a == int'(cursor_addr) && r == 7) p = 5'h1F;
      w[39 - 5 * k -: 5] = p;
    end
    return w;
  endfunction

  // oscillator tick generator
  initial forever begin
    @(posedge clk);
    begin : osc_gen
      int cnt;
      cnt = 0;
      forever begin
        osc_en <= (cnt == 0);
        cnt = (cnt + 1 >= div_sel) ? 0 : cnt + 1;
        @(posedge clk);
      end
    end
  end

  // pattern source model, driven at falling edges
  initial begin
    int s = 0, w = 0, ha = 0, hr = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        s = 0; w = 0; pat_req_ready = 0; pat_rsp_valid = 0;
      end else if (s == 0) begin
        if (pat_req_valid) begin
          if (w == 0) begin ha = pat_req_addr; hr = pat_req_row; end
          else chk("R7 request held under back-pressure", {pat_req_addr, pat_req_row}, {7'(ha), 4'(hr)});
          if (w >= stall) begin pat_req_ready = 1; s = 1; w = 0; end
          else w++;
        end
      end else if (s == 1) begin
        pat_req_ready = 0; pat_rsp_valid = 1; pat_rsp_data = pat(ha, hr); s = 2;
      end else begin
        pat_rsp_valid = 0; s = 0;
      end
    end
  end

  // segment-chain monitor
  logic [39:0] cap = '0, last_word = '0;
  int capn = 0, last_n = 0, gap = 0, last_gap = 0, latch_cnt = 0, lat_w = 0, shift_in_latch = 0;
  initial begin
    logic ps = 0, pl = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cap = '0; capn = 0; gap = 0; ps = 0; pl = 0; lat_w = 0;
      end else begin
        gap++;
        if (seg_shift_o && !ps) begin
          cap = {cap[38:0], seg_data_o}; capn++;
          if (seg_latch_o) shift_in_latch++;
        end
        if (seg_latch_o) lat_w++;
        if (seg_latch_o && !pl) begin
          last_word = cap; last_n = capn; cap = '0; capn = 0;
          last_gap = gap; gap = 0; latch_cnt++; lat_w = 1;
        end
        ps = seg_shift_o; pl = seg_latch_o;
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_rows(input int nrows, input string wtag, input int sw_at,
                          input bit sw_two, input bit sw_tall);
    int c = 0, f = 0, tgt, lc, k0, ex_gap;
    bit mq_two, mq_tall;
    do_reset();
    mq_two = two_line; mq_tall = tall_font;
    for (int i = 0; i < nrows; i++) begin
      k0 = latch_cnt;
      wait (latch_cnt != k0);
      lc = last_c(mq_two, mq_tall);
      tgt = (c >= lc) ? 0 : c + 1;
      chk({wtag, " segment word"}, 64'(last_word), 64'(exp_word(tgt, mq_two, ((f / BF) % 2) == 1)));
      chk("R4 bits per row", 64'(last_n), 64'd40);
      if (i > 0) begin
        ex_gap = (mq_two ? RS : RL) * div_sel;
        chk("R2 row length", 64'(last_gap), 64'(ex_gap));
      end
      while (seg_latch_o) @(negedge clk);
      chk("R5 latch width", 64'(lat_w), 64'(div_sel));
      chk("R5 no shift during latch", 64'(shift_in_latch), 64'd0);
      chk("R1 R3 common select", 64'(com_o), 64'(16'd1 << tgt));
      if (tgt == 0) begin
        f++;
        mq_two = two_line; mq_tall = tall_font;
      end
      chk("R8 frame polarity", 64'(ac_flip_o), 64'(f % 2));
      c = tgt;
      if (i == sw_at) begin two_line = sw_two; tall_font = sw_tall; end
    end
  endtask

  task automatic set_mode(bit two, bit tall, bit on, bit cur, bit blk, int ca, int dv, int st);
    two_line = two; tall_font = tall; disp_on = on; cursor_on = cur; blink_on = blk;
    cursor_addr = 7'(ca); div_sel = dv; stall = st;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (5) @(negedge clk);
    chk("R13 reset com", 64'(com_o), 64'h1);
    chk("R13 reset outputs", 64'({ac_flip_o, seg_latch_o, seg_shift_o, seg_data_o, pat_req_valid}), 64'h0);
  endtask

  task automatic t_eight_rows_cursor();
    set_mode(0, 0, 1, 1, 0, 3, 1, 0);
    run_rows(20, "R6 R9 one-line cursor", -1, 0, 0);
  endtask

  task automatic t_eleven_rows();
    set_mode(0, 1, 1, 1, 0, 5, 1, 1);
    run_rows(14, "R1 R9 eleven-row cell", -1, 0, 0);
  endtask

  task automatic t_two_line_stall();
    set_mode(1, 1, 1, 1, 0, 7'h42, 1, 3);
    run_rows(20, "R6 R7 two-line", -1, 0, 0);
  endtask

  task automatic t_blink();
    set_mode(0, 0, 1, 0, 1, 6, 1, 0);
    run_rows(40, "R10 blink phase", -1, 0, 0);
  endtask

  task automatic t_display_off();
    set_mode(1, 0, 0, 1, 1, 0, 1, 0);
    run_rows(18, "R11 display off", -1, 0, 0);
  endtask

  task automatic t_slow_osc();
    set_mode(1, 0, 1, 0, 0, 0, 3, 0);
    run_rows(10, "R2 R5 slow oscillator", -1, 0, 0);
  endtask

  task automatic t_mode_switch();
    set_mode(1, 0, 1, 1, 0, 2, 1, 0);
    run_rows(30, "R12 mode switch", 2, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_eight_rows_cursor();
    t_eleven_rows();
    t_two_line_stall();
    t_blink();
    t_display_off();
    t_slow_osc();
    t_mode_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule